// File: doc/BRIEF.md
# Audio Transmit FIFO Channel

One playback channel of an audio codec controller. The host writes 32-bit words into a small data FIFO, and a frame sequencer asks the channel for one sample per PCM slot of each outgoing frame. The channel unpacks every word into a 12-, 16-, 18- or 20-bit sample, or into two 16-bit samples in compact mode. It answers only for the slots that are switched on, and it reports its fill level, its activity and any starvation through a status word and a small set of maskable interrupts.

A frame is a `frame_start` strobe followed by `slot_req` strobes carrying the slot number, in ascending order and ending with slot 12. Each enabled request is answered on the next cycle by `slot_vld` and `slot_data`. Pulling the global interface enable low empties the FIFO. Clearing the channel's own transmit enable only stops sample delivery.

Top module: `audio_tx_channel`

## Requirements
- R1: `ctl_q` returns the last word written through `ctl_we`. The fields are: bit 16 FIFO enable, bit 15 compact mode, bits 14:13 sample size, bits 12:1 per-slot enables for slots 1 to 12, and bit 0 channel transmit enable. The reset value is 0.
- R2: In normal mode, each enabled slot request pops one word. The low bits of the word are returned, zero-extended to 20 bits, one cycle after the request. The size code selects the width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 12.
- R3: In compact mode, a word yields two 16-bit samples, first bits 15:0 and then bits 31:16. The word stays in the FIFO until its second sample is taken.
- R4: A request produces an answer only when all of these hold: the transmit enable is set, the slot number is between 3 and 12, and that slot's enable bit is set. Any other request gives no `slot_vld` and leaves the FIFO untouched.
- R5: With FIFO enable set, the FIFO holds DEPTH words, and status bit 5 (full) is set at DEPTH. A word written while the FIFO is full is dropped.
- R6: With FIFO enable clear, the FIFO holds a single word. Full is set at one word, and a second write is dropped.
- R7: Status bit 1 (empty) is set when no word is held. Status bit 3 (half-empty) is set when the count is at most half the capacity.
- R8: An enabled request that finds the FIFO empty returns 0 and sets status bit 9 (underrun). The flag stays set until it is cleared.
- R9: Writing the clear word with bit 5 set clears the underrun flag. The other bits of the clear word have no effect on it.
- R10: Status bit 7 (busy) is set while the transmit enable is on and either the FIFO holds data or a frame is in progress. A frame is in progress from `frame_start` until the slot 12 request.
- R11: `isr_q` is the raw interrupt set ANDed with the enable register. The raw set is: bit 0 FIFO empty, bit 2 half-empty request, bit 5 underrun. `irq` is the OR of `isr_q`.
- R12: Clearing the transmit enable keeps the FIFO contents. Holding `if_en` low empties the FIFO and drops writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Global interface enable; low flushes the FIFO |
| ctl_we | input | 1 | Write strobe for the transmit control register |
| ctl_wdata | input | 17 | Transmit control write data |
| ctl_q | output | 17 | Transmit control readback |
| ie_we | input | 1 | Write strobe for the interrupt enable register |
| ie_wdata | input | 7 | Interrupt enable write data |
| clr_we | input | 1 | Write strobe for the interrupt clear word |
| clr_wdata | input | 13 | Interrupt clear word; bit 5 clears underrun |
| dat_we | input | 1 | FIFO data write strobe |
| dat_wdata | input | 32 | FIFO data word |
| frame_start | input | 1 | Start-of-frame strobe |
| slot_req | input | 1 | Slot sample request |
| slot_idx | input | 4 | Slot number of the request |
| slot_vld | output | 1 | Sample answer valid |
| slot_data | output | 20 | Sample, zero-extended |
| stat_q | output | 12 | Status word |
| isr_q | output | 7 | Masked interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
Every register write, FIFO write, flush and clear takes effect at the clock edge that samples it, so `ctl_q`, `stat_q`, `isr_q` and `irq` are compared at the following falling edge. A sample answer is due exactly one cycle after its request. The bench pushes the expected sample into a queue when it issues an enabled request, and a monitor pops and compares on every falling edge where `slot_vld` is high. An answer nobody asked for is an error, and so is a request left without an answer at the end of the run.

// File: rtl/audio_tx_channel.sv
module audio_tx_channel #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        if_en,
  input  logic        ctl_we,
  input  logic [16:0] ctl_wdata,
  output logic [16:0] ctl_q,
  input  logic        ie_we,
  input  logic [6:0]  ie_wdata,
  input  logic        clr_we,
  input  logic [12:0] clr_wdata,
  input  logic        dat_we,
  input  logic [31:0] dat_wdata,
  input  logic        frame_start,
  input  logic        slot_req,
  input  logic [3:0]  slot_idx,
  output logic        slot_vld,
  output logic [19:0] slot_data,
  output logic [11:0] stat_q,
  output logic [6:0]  isr_q,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [16:0]   ctl;
  logic [6:0]    ie;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          half, ur, in_frame;
  logic [19:0]   sample;

  wire txen = ctl[0];
  wire fen  = ctl[16];
  wire cmp  = ctl[15];
  wire [1:0] ssz = ctl[14:13];

  wire [CW-1:0] cap = fen ? CW'(DEPTH) : CW'(1);
  wire empty   = (cnt == '0);
  wire full    = (cnt >= cap);
  wire hempty  = (cnt <= (cap >> 1));
  wire busy    = txen && (!empty || in_frame);

  wire slot_on = slot_req && txen && (slot_idx >= 4'd3) && (slot_idx <= 4'd12)
                 && ctl[{1'b0, slot_idx}];
  wire take    = slot_on && !empty;
  wire dry     = slot_on && empty;
  wire pop     = take && (!cmp || half);
  wire push    = dat_we && if_en && !full;

  wire [31:0] head = mem[rp];

  always_comb begin
    if (cmp) sample = {4'b0, half ? head[31:16] : head[15:0]};
    else begin
      case (ssz)
        2'd0:    sample = {4'b0, head[15:0]};
        2'd1:    sample = {2'b0, head[17:0]};
        2'd2:    sample = head[19:0];
        default: sample = {8'b0, head[11:0]};
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= dat_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; ie <= '0; wp <= '0; rp <= '0; cnt <= '0;
      half <= 1'b0; ur <= 1'b0; in_frame <= 1'b0;
      slot_vld <= 1'b0; slot_data <= '0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      if (ie_we)  ie  <= ie_wdata;
      if (!if_en) begin
        wp <= '0; rp <= '0; cnt <= '0; half <= 1'b0;
      end else begin
        if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
        if (take && cmp) half <= !half;
      end
      if (dry) ur <= 1'b1;
      else if (clr_we && clr_wdata[5]) ur <= 1'b0;
      if (frame_start) in_frame <= 1'b1;
      else if (slot_req && slot_idx == 4'd12) in_frame <= 1'b0;
      slot_vld  <= slot_on;
      slot_data <= take ? sample : '0;
    end
  end

  assign ctl_q  = ctl;
  assign stat_q = {2'b0, ur, 1'b0, busy, 1'b0, full, 1'b0, hempty, 1'b0, empty, 1'b0};
  assign isr_q  = {1'b0, ur, 2'b0, hempty, 1'b0, empty} & ie;
  assign irq    = |isr_q;
endmodule

// File: rtl/audio_tx_channel_chk.sv
module audio_tx_channel_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          if_en,
  input logic [CW-1:0] cnt,
  input logic [16:0]   ctl_q,
  input logic [11:0]   stat_q,
  input logic [6:0]    ie_q,
  input logic          slot_vld,
  input logic [19:0]   slot_data,
  input logic          clr_we,
  input logic [12:0]  clr_wdata,
  input logic          irq
);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_ur_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[9] && !(clr_we && clr_wdata[5]) |=> stat_q[9]);

  p_dry_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld && $rose(stat_q[9]) |-> slot_data == 20'd0);

  p_txen_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |=> !slot_vld);

  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> stat_q[1]);

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q != 7'd0);
endmodule

bind audio_tx_channel audio_tx_channel_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .cnt(cnt), .ctl_q(ctl_q),
  .stat_q(stat_q), .ie_q(ie), .slot_vld(slot_vld), .slot_data(slot_data),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .irq(irq)
);

// File: tb/audio_tx_channel_tb_top.sv
`timescale 1ns/1ps
module audio_tx_channel_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, if_en = 1'b1;
  logic ctl_we = 0, ie_we = 0, clr_we = 0, dat_we = 0, frame_start = 0, slot_req = 0;
  logic [16:0] ctl_wdata = '0;
  logic [6:0]  ie_wdata = '0;
  logic [12:0] clr_wdata = '0;
  logic [31:0] dat_wdata = '0;
  logic [3:0]  slot_idx = '0;
  logic [16:0] ctl_q;
  logic        slot_vld, irq;
  logic [19:0] slot_data;
  logic [11:0] stat_q;
  logic [6:0]  isr_q;

  int checks = 0, errors = 0;
  logic [19:0] expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  audio_tx_channel #(.DEPTH(8)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && slot_vld) begin
    if (expq.size() == 0) chk("R4 unexpected sample", 32'(slot_data), 32'hFFFFFFFF);
    else chk(tagq.pop_front(), 32'(slot_data), 32'(expq.pop_front()));
  end

  task automatic step();
    @(posedge clk); #1;
    ctl_we = 0; ie_we = 0; clr_we = 0; dat_we = 0; frame_start = 0; slot_req = 0;
  endtask
  task automatic wctl(logic [16:0] v);
    @(posedge clk); #1; ctl_we = 1; ctl_wdata = v; step();
    @(negedge clk); chk("R1 control readback", 32'(ctl_q), 32'(v));
  endtask
  task automatic wdat(logic [31:0] v);
    @(posedge clk); #1; dat_we = 1; dat_wdata = v; step();
  endtask
  task automatic req(logic [3:0] s, bit exp_on, logic [19:0] e, string tag);
    @(posedge clk); #1; slot_req = 1; slot_idx = s;
    if (exp_on) begin expq.push_back(e); tagq.push_back(tag); end
    step();
  endtask
  task automatic fstart();
    @(posedge clk); #1; frame_start = 1; step();
  endtask
  task automatic stat(logic [11:0] e, string tag);
    @(negedge clk); chk(tag, 32'(stat_q), 32'(e));
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset control", 32'(ctl_q), 0);
    chk("R7 reset status", 32'(stat_q), 32'h00A);
    chk("R11 reset irq", 32'(irq), 0);

    wctl(17'h10019);
    wdat(32'hABCD_1234); wdat(32'h0000_9876);
    stat(12'h088, "R10 busy with data");
    fstart();
    stat(12'h088, "R10 busy in frame");
    req(3, 1, 20'h01234, "R2 size16 slot3");
    req(4, 1, 20'h09876, "R2 size16 slot4");
    req(5, 0, 0, "");
    req(12, 0, 0, "");
    stat(12'h00A, "R10 idle after frame");

    wctl(17'h12019); wdat(32'hFFFF_FFFF); req(3, 1, 20'h3FFFF, "R2 size18");
    wctl(17'h14019); wdat(32'h1234_5678); req(3, 1, 20'h45678, "R2 size20");
    wctl(17'h16019); wdat(32'hFFFF_FABC); req(3, 1, 20'h00ABC, "R2 size12");

    wctl(17'h18019); wdat(32'h1234_5678);
    req(3, 1, 20'h05678, "R3 compact low half");
    stat(12'h088, "R3 word held after first half");
    req(4, 1, 20'h01234, "R3 compact high half");
    stat(12'h00A, "R3 word released");

    wctl(17'h107F9);
    for (int i = 1; i <= 9; i++) wdat(32'h100 + 32'(i));
    stat(12'h0A0, "R5 full at depth");
    fstart();
    for (int s = 3; s <= 10; s++) req(4'(s), 1, 20'h100 + 20'(s - 2), "R5 drain order, ninth dropped");
    req(11, 0, 0, "");
    req(12, 0, 0, "");
    stat(12'h00A, "R5 drained");

    req(3, 1, 20'h0, "R8 dry slot sends zero");
    stat(12'h20A, "R8 underrun set");
    @(posedge clk); #1; ie_we = 1; ie_wdata = 7'h20; step();
    @(negedge clk); chk("R11 underrun isr", 32'(isr_q), 32'h20); chk("R11 irq", 32'(irq), 1);
    @(posedge clk); #1; clr_we = 1; clr_wdata = 13'h1FDF; step();
    stat(12'h20A, "R9 other clear bits ignored");
    @(posedge clk); #1; clr_we = 1; clr_wdata = 13'h0020; step();
    stat(12'h00A, "R9 underrun cleared");
    @(negedge clk); chk("R11 irq after clear", 32'(irq), 0);

    @(posedge clk); #1; ie_we = 1; ie_wdata = 7'h05; step();
    @(negedge clk); chk("R11 empty and half isr", 32'(isr_q), 32'h05);
    for (int i = 0; i < 5; i++) wdat(32'h50 + 32'(i));
    stat(12'h080, "R7 above half");
    @(negedge clk); chk("R11 isr off above half", 32'(isr_q), 0);

    wctl(17'h107F8);
    req(3, 0, 0, "");
    stat(12'h000, "R12 txen off keeps data");
    @(posedge clk); #1; if_en = 0; @(posedge clk); #1; if_en = 1;
    stat(12'h00A, "R12 if_en low flushes");

    wctl(17'h00019);
    wdat(32'h0000_0111); wdat(32'h0000_0222);
    stat(12'h0A0, "R6 single word full");
    req(3, 1, 20'h00111, "R6 first word kept");
    stat(12'h00A, "R6 empty after one");

    repeat (3) @(negedge clk);
    chk("R2 all requests answered", 32'(expq.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule